// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block gives a small CPU core two hardware breakpoints on instruction fetch. Each channel holds a programmable match address and an enable bit, both written over a simple register write port. The core presents the start address of every instruction it is about to execute, together with a strobe and a pre-decoded opcode class. When an enabled channel's address equals that start address, the block raises a request to the core before the instruction runs. No interrupt mask or priority level gates this request.

While the request is pending, the block also reports the winning channel and the program-counter value the core must push on the stack. This value is not a clean return address. It is the match address plus one or plus two, chosen by the opcode class. The request stays up until the core acknowledges it. Instruction decoding, stacking and vector fetch belong to the core.

Top module: `addr_brk_unit`

## Requirements
- R1: After reset both match addresses are zero, both channels are disabled and `brk_req` is low. A strobe at address 0 right after reset gives no request.
- R2: Register writes use `reg_sel`. Value 0 selects the channel 0 address and value 1 selects the channel 1 address. Value 2 selects the enable bits, with `reg_wdata[0]` enabling channel 0 and `reg_wdata[1]` enabling channel 1. Value 3 has no effect.
- R3: A channel requests only when its enable bit is set. A disabled channel whose address matches gives no request.
- R4: When `instr_start` is high and an enabled channel's address equals `instr_addr`, `brk_req` is high from the first rising edge after that cycle onward.
- R5: For class 2 (16-bit opcode) and class 3, `brk_pc` is the match address plus 2, modulo 2^20.
- R6: For class 1 (listed 8-bit opcode), `brk_pc` is the match address plus 2, modulo 2^20.
- R7: For class 0 (other 8-bit opcode), `brk_pc` is the match address plus 1, modulo 2^20.
- R8: If both channels match in the same cycle, `brk_chan` is 0. Otherwise `brk_chan` is the index of the matching channel.
- R9: `brk_req`, `brk_chan` and `brk_pc` hold until `brk_ack` is sampled high. The request is then low from the next edge. An acknowledge with no request pending has no effect.
- R10: A strobe that arrives while a request is pending creates no new request and leaves `brk_chan` and `brk_pc` unchanged.
- R11: An address write in the same cycle as a strobe does not affect that comparison. The new value applies from the next strobe.
- R12: An address equal to a match register gives no request while `instr_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0/1 address, 2 enables) |
| reg_wdata | input | 20 | Register write data |
| instr_start | input | 1 | Instruction start strobe |
| instr_addr | input | 20 | Start address of the next instruction |
| instr_class | input | 2 | Decoded opcode class |
| brk_ack | input | 1 | One-cycle acknowledge from the core |
| brk_req | output | 1 | Breakpoint request |
| brk_chan | output | 1 | Winning channel index |
| brk_pc | output | 20 | Program-counter value to stack |

## Verification
A corrupted match or enable register shows up at the ports only at the next strobe on the affected address. It appears either as a request where none belongs or as a missing one. The sweep therefore probes each channel's address, the other channel's address and an unrelated address under all four enable settings. A wrong pending state shows one edge after a strobe or an acknowledge as a stuck or early `brk_req`, or as a `brk_pc` or `brk_chan` that drifts while it is held. The checks sample every such edge. Offset faults appear at once in `brk_pc`, including the wrap at the top address.

// File: rtl/abu_pkg.sv
package abu_pkg;
  typedef enum logic [1:0] {
    CLS_SHORT  = 2'd0,
    CLS_LISTED = 2'd1,
    CLS_WIDE   = 2'd2,
    CLS_RSVD   = 2'd3
  } op_class_e;

  // step from match address to the stacked PC value
  function automatic logic [1:0] pc_step(input logic [1:0] cls);
    return (cls == CLS_SHORT) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/abu_regs.sv
module abu_regs #(
  parameter int AW   = 20,
  parameter int NCH  = 2,
  parameter int SELW = $clog2(NCH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [SELW-1:0]         sel,
  input  logic [AW-1:0]           wdata,
  output logic [NCH-1:0][AW-1:0]  match_addr,
  output logic [NCH-1:0]          en
);
  localparam int EN_SEL = NCH;

  for (genvar g = 0; g < NCH; g++) begin : g_addr
    always_ff @(posedge clk) begin
      if (!rst_n)                                  match_addr[g] <= '0;
      else if (we && sel == SELW'(g))              match_addr[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             en <= '0;
    else if (we && sel == SELW'(EN_SEL))    en <= wdata[NCH-1:0];
  end
endmodule

// File: rtl/abu_cmp.sv
module abu_cmp #(
  parameter int AW = 20
) (
  input  logic          start,
  input  logic          en,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  assign hit = start & en & (ref_addr == addr);
endmodule

// File: rtl/abu_arb.sv
module abu_arb
  import abu_pkg::*;
#(
  parameter int AW  = 20,
  parameter int NCH = 2,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic [AW-1:0]  addr,
  input  logic [1:0]     cls,
  input  logic           ack,
  output logic           req,
  output logic [CW-1:0]  chan,
  output logic [AW-1:0]  pc
);
  logic [CW-1:0] win;
  logic          any_hit;
  logic          take;

  // lowest index wins
  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hit[i]) win = CW'(i);
    end
  end

  assign any_hit = |hit;
  assign take    = any_hit & ~req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= 1'b0;
      chan <= '0;
      pc   <= '0;
    end else if (req) begin
      if (ack) req <= 1'b0;
    end else if (take) begin
      req  <= 1'b1;
      chan <= win;
      pc   <= addr + AW'(pc_step(cls));
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req && $stable(chan) && $stable(pc));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req && ack |=> !req);
  p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) && ($past(cls) != 2'd0) |-> pc == $past(addr) + AW'(2));
  p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) && ($past(cls) == 2'd0) |-> pc == $past(addr) + AW'(1));
endmodule

// File: rtl/addr_brk_unit.sv
module addr_brk_unit #(
  parameter int AW   = 20,
  parameter int NCH  = 2,
  parameter int SELW = $clog2(NCH + 1),
  parameter int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [SELW-1:0] reg_sel,
  input  logic [AW-1:0]   reg_wdata,
  input  logic            instr_start,
  input  logic [AW-1:0]   instr_addr,
  input  logic [1:0]      instr_class,
  input  logic            brk_ack,
  output logic            brk_req,
  output logic [CW-1:0]   brk_chan,
  output logic [AW-1:0]   brk_pc
);
  logic [NCH-1:0][AW-1:0] match_addr;
  logic [NCH-1:0]         en_q;
  logic [NCH-1:0]         hit;

  abu_regs #(.AW(AW), .NCH(NCH), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel),
    .wdata(reg_wdata), .match_addr(match_addr), .en(en_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    abu_cmp #(.AW(AW)) u_cmp (
      .start(instr_start), .en(en_q[g]), .ref_addr(match_addr[g]),
      .addr(instr_addr), .hit(hit[g])
    );
  end

  abu_arb #(.AW(AW), .NCH(NCH), .CW(CW)) u_arb (
    .clk(clk), .rst_n(rst_n), .hit(hit), .addr(instr_addr),
    .cls(instr_class), .ack(brk_ack),
    .req(brk_req), .chan(brk_chan), .pc(brk_pc)
  );

  p_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> (($past(en_q) >> brk_chan) & NCH'(1)) != '0);
  p_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> $past(instr_start));
  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) && $past(hit[0]) |-> brk_chan == '0);
  p_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_req && (hit != '0) |=> brk_req);
endmodule

// File: tb/test_addr_brk_unit.sv
module test_addr_brk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [19:0] reg_wdata = '0;
  logic        instr_start = 1'b0;
  logic [19:0] instr_addr = '0;
  logic [1:0]  instr_class = '0;
  logic        brk_ack = 1'b0;
  logic        brk_req;
  logic [0:0]  brk_chan;
  logic [19:0] brk_pc;

  int n_chk = 0;
  int n_bad = 0;
  logic [19:0] m_addr [2];
  logic [1:0]  m_en;

  always #5 clk = ~clk;

  addr_brk_unit i_addr_brk_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .instr_start(instr_start), .instr_addr(instr_addr),
    .instr_class(instr_class), .brk_ack(brk_ack),
    .brk_req(brk_req), .brk_chan(brk_chan), .brk_pc(brk_pc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [19:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (s < 2) m_addr[s] = d;
    else if (s == 2) m_en = d[1:0];
  endtask

  // one strobe; returns at the falling edge after the sampling edge
  task automatic strobe(input logic [19:0] a, input logic [1:0] c);
    @(negedge clk);
    instr_start = 1'b1; instr_addr = a; instr_class = c;
    @(negedge clk);
    instr_start = 1'b0;
  endtask

  task automatic do_ack();
    brk_ack = 1'b1;
    @(negedge clk);
    brk_ack = 1'b0;
  endtask

  function automatic logic [19:0] exp_pc(input logic [19:0] a, input logic [1:0] c);
    return (c == 2'd0) ? a + 20'd1 : a + 20'd2;
  endfunction

  task automatic probe(input logic [19:0] a, input logic [1:0] c);
    logic h0, h1;
    h0 = m_en[0] && (a == m_addr[0]);
    h1 = m_en[1] && (a == m_addr[1]);
    strobe(a, c);
    check("R3/R4 req", brk_req, h0 | h1);
    if (h0 | h1) begin
      check("R8 chan", brk_chan, h0 ? 0 : 1);
      if (c == 2'd0)      check("R7 pc", brk_pc, exp_pc(a, c));
      else if (c == 2'd1) check("R6 pc", brk_pc, exp_pc(a, c));
      else                check("R5 pc", brk_pc, exp_pc(a, c));
      do_ack();
      check("R9 cleared", brk_req, 0);
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    m_addr[0] = '0; m_addr[1] = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req after reset", brk_req, 0);
    strobe(20'h0, 2'd0);
    check("R1 disabled at reset", brk_req, 0);

    wr(2'd0, 20'h00100);
    wr(2'd1, 20'hFFFFF);
    wr(2'd3, 20'h00003);  // R2: select 3 has no effect
    probe(20'h00100, 2'd0);
    check("R2 sel 3 ignored", brk_req, 0);

    // sweep of enables, classes and addresses
    for (int e = 0; e < 4; e++) begin
      wr(2'd2, 20'(e));
      for (int c = 0; c < 4; c++) begin
        probe(20'h00100, 2'(c));
        probe(20'hFFFFF, 2'(c));
        probe(20'h00200, 2'(c));
      end
    end

    // R8: both channels on the same address
    wr(2'd1, 20'h00100);
    probe(20'h00100, 2'd2);
    wr(2'd1, 20'hFFFFF);

    // R9/R10: hold without ack, strobes while pending
    strobe(20'h00100, 2'd1);
    repeat (3) @(negedge clk);
    check("R9 held", brk_req, 1);
    strobe(20'hFFFFF, 2'd0);
    check("R10 chan kept", brk_chan, 0);
    check("R10 pc kept", brk_pc, 20'h00102);
    do_ack();
    check("R9 cleared after ack", brk_req, 0);
    do_ack();  // R9: ack with nothing pending
    check("R9 idle ack", brk_req, 0);
    strobe(20'h00200, 2'd0);
    check("R10 no late request", brk_req, 0);

    // R11: write in the same cycle as the strobe
    @(negedge clk);
    instr_start = 1'b1; instr_addr = 20'h00100; instr_class = 2'd0;
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 20'h00300;
    @(negedge clk);
    instr_start = 1'b0; reg_we = 1'b0; m_addr[0] = 20'h00300;
    check("R11 old address used", brk_req, 1);
    check("R11 pc", brk_pc, 20'h00101);
    do_ack();
    probe(20'h00100, 2'd0);
    probe(20'h00300, 2'd2);

    // R12: matching address without strobe
    @(negedge clk);
    instr_addr = 20'h00300; instr_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R12 no strobe", brk_req, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule